// File: doc/BRIEF.md
# Immediate-Offset Word Load Unit

This block executes one word load whose address is a base register plus or minus an unsigned immediate. It accepts a 32-bit instruction word together with a mode select. The mode select chooses between the fixed-width instruction set and the compact instruction set. In compact mode the word may hold a single 16-bit instruction or a 32-bit instruction split into two halfwords.

The unit decodes the fields and reads the base register through a combinational read port. It computes the offset address and the access address. It then performs one read on a valid/ready memory port. When the response arrives, it presents the register writes for one cycle: the loaded word to the target register, and the offset address to the base register when write-back is requested. A load into the program counter appears on a branch output instead of the register write port.

Encodings that are illegal, unpredictable, or belong to a different load instruction are reported on four flag outputs. These flags are valid while `done_o` is high. In those cases the unit makes no memory access and no register writes. Condition codes and exceptions are handled outside the block.

Top module: `ldr_imm_unit`

## Requirements
- R1: After reset the unit is idle: `ready_o` is 1, and `mem_req_o`, `done_o`, `rf_we_o`, `wb_we_o` and `branch_o` are 0.
- R2: With `fixed_mode_i`=1, a word with bits 27:25=010, bit 22=0 and bit 20=1 is a load. The other fields are:
  - index flag P at bit 24, add flag U at bit 23, write-back flag W at bit 21;
  - base register at bits 19:16, target register at bits 15:12;
  - a zero-extended 12-bit offset at bits 11:0.
  Write-back is requested when P=0 or W=1. Any other fixed-width word sets `flag_undef_o`.
- R3: The offset address is base+offset when add is set and base−offset otherwise. The access address is the offset address when indexing is on, and the unmodified base when it is off. When write-back is requested, `wb_we_o` writes the offset address to the base register in the same cycle as the target write.
- R4: Compact form with bits 15:11=01101:
  - offset field in bits 10:6, scaled by 4;
  - base register in bits 5:3, target register in bits 2:0;
  - always indexed and adding, with no write-back.
  Bits 31:16 are ignored.
- R5: Compact form with bits 15:11=10011:
  - target register in bits 10:8;
  - offset in bits 7:0, scaled by 4;
  - base is always register 13;
  - always indexed and adding, with no write-back.
- R6: Compact 32-bit form with bits 15:4=0xF8D:
  - base register in bits 3:0;
  - target register in bits 31:28;
  - a 12-bit offset in bits 27:16;
  - indexed, adding, no write-back.
  A compact word is 32-bit when bits 15:11 are 11101, 11110 or 11111.
- R7: Compact 32-bit form with bits 15:4=0xF85 and bit 27=1:
  - base register in bits 3:0, target register in bits 31:28;
  - P at bit 26, U at bit 25, W at bit 24;
  - an 8-bit offset in bits 23:16;
  - write-back equals W.
  P=0 with W=0 sets `flag_undef_o`.
- R8: A base register field equal to 15 sets `flag_literal_o` in every form except the register-13 form.
- R9: Fixed-width P=0 with W=1 sets `flag_unpriv_o`. In the compact form with bits 15:4=0xF85, P=1, U=1, W=0 sets `flag_unpriv_o`.
- R10: Write-back requested with base equal to target sets `flag_unpred_o`. Every flagged instruction makes no memory request and no register or branch write. At most one flag is set, and the priority is literal, then unprivileged, then undefined.
- R11: With target 15 and access address bits 1:0 equal to 00, the loaded word appears on `branch_target_o` with `branch_o`, and `rf_we_o` stays 0. With other address bits, the load is performed, `flag_unpred_o` is set, and no write of any kind is made.
- R12: `mem_req_o` stays high with a stable `mem_addr_o` until `mem_gnt_i`. Exactly one read is issued per executed instruction. `done_o` pulses for one cycle, in the cycle after `mem_rvalid_i`.
- R13: A compact word matching none of the four compact forms sets `flag_undef_o`. This includes the 0xF85 form with bit 27=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| fixed_mode_i | input | 1 | 1 = fixed-width encoding, 0 = compact encoding |
| start_i | input | 1 | Instruction valid; accepted while ready_o is high |
| instr_i | input | 32 | Instruction word; second compact halfword in bits 31:16 |
| ready_o | output | 1 | Unit idle and able to accept |
| rf_raddr_o | output | 4 | Base register read address |
| rf_rdata_i | input | DATA_W | Base register value |
| mem_req_o | output | 1 | Memory read request valid |
| mem_addr_o | output | DATA_W | Memory read address |
| mem_gnt_i | input | 1 | Memory request ready |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| done_o | output | 1 | Instruction complete; writes and flags valid |
| rf_we_o | output | 1 | Target register write enable |
| rf_waddr_o | output | 4 | Target register index |
| rf_wdata_o | output | DATA_W | Loaded word |
| wb_we_o | output | 1 | Base register write-back enable |
| wb_addr_o | output | 4 | Base register index |
| wb_data_o | output | DATA_W | Updated base value |
| branch_o | output | 1 | Loaded word is a branch target |
| branch_target_o | output | DATA_W | Branch target |
| flag_undef_o | output | 1 | Undefined encoding |
| flag_literal_o | output | 1 | Belongs to the literal-load instruction |
| flag_unpriv_o | output | 1 | Belongs to the unprivileged-load instruction |
| flag_unpred_o | output | 1 | Unpredictable; discarded |

## Verification
The assertions check several properties on every cycle:
- the memory request holds with a stable address until granted;
- `done_o` is a single-cycle pulse;
- a flagged instruction never writes;
- a branch never coincides with a register write;
- the flags are mutually exclusive;
- base write-back occurs only with completion.

Only the bench scenarios can show the rest. That covers the field extraction of each of the five forms, offset scaling and the implicit register-13 base, and the add/subtract and pre/post-index arithmetic. It also covers which encodings map to which flag, and the alignment-dependent handling of program-counter loads. These are compared against addresses and data computed arithmetically from the field values.

// File: rtl/ldr_imm_pkg.sv
package ldr_imm_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned IMM_W  = 12;
  localparam logic [REG_AW-1:0] PC_IDX = 4'd15;
  localparam logic [REG_AW-1:0] SP_IDX = 4'd13;
  localparam logic [11:0] WIDE_OFS_OP  = 12'hF8D;
  localparam logic [11:0] WIDE_IDX_OP  = 12'hF85;
  localparam logic [4:0]  NARROW_R_OP  = 5'b01101;
  localparam logic [4:0]  NARROW_SP_OP = 5'b10011;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} seq_state_e;

  typedef struct packed {
    logic [REG_AW-1:0] rn;
    logic [REG_AW-1:0] rt;
    logic [IMM_W-1:0]  imm;
    logic              index;
    logic              add;
    logic              wback;
    logic              undef;
    logic              lit;
    logic              unpriv;
  } ld_dec_t;
endpackage

// File: rtl/ldr_imm_decode.sv
module ldr_imm_decode
  import ldr_imm_pkg::*;
(
  input  logic [31:0] instr_i,
  input  logic        fixed_mode_i,
  output ld_dec_t     dec_o
);
  logic [15:0] hw0, hw1;
  logic        is_wide;

  assign hw0     = instr_i[15:0];
  assign hw1     = instr_i[31:16];
  assign is_wide = (hw0[15:13] == 3'b111) && (hw0[12:11] != 2'b00);

  always_comb begin
    dec_o       = '0;
    dec_o.undef = 1'b1;
    if (fixed_mode_i) begin
      if (instr_i[27:25] == 3'b010 && !instr_i[22] && instr_i[20]) begin
        dec_o.undef = 1'b0;
        dec_o.rn    = instr_i[19:16];
        dec_o.rt    = instr_i[15:12];
        dec_o.imm   = instr_i[11:0];
        dec_o.index = instr_i[24];
        dec_o.add   = instr_i[23];
        dec_o.wback = !instr_i[24] || instr_i[21];
        if (dec_o.rn == PC_IDX)               dec_o.lit    = 1'b1;
        else if (!instr_i[24] && instr_i[21]) dec_o.unpriv = 1'b1;
      end
    end else if (is_wide) begin
      if (hw0[15:4] == WIDE_OFS_OP) begin
        dec_o.undef = 1'b0;
        dec_o.rn    = hw0[3:0];
        dec_o.rt    = hw1[15:12];
        dec_o.imm   = hw1[11:0];
        dec_o.index = 1'b1;
        dec_o.add   = 1'b1;
        dec_o.lit   = (hw0[3:0] == PC_IDX);
      end else if (hw0[15:4] == WIDE_IDX_OP && hw1[11]) begin
        dec_o.undef = 1'b0;
        dec_o.rn    = hw0[3:0];
        dec_o.rt    = hw1[15:12];
        dec_o.imm   = {4'b0, hw1[7:0]};
        dec_o.index = hw1[10];
        dec_o.add   = hw1[9];
        dec_o.wback = hw1[8];
        if (hw0[3:0] == PC_IDX)                dec_o.lit    = 1'b1;
        else if (hw1[10] && hw1[9] && !hw1[8]) dec_o.unpriv = 1'b1;
        else if (!hw1[10] && !hw1[8])          dec_o.undef  = 1'b1;
      end
    end else if (hw0[15:11] == NARROW_R_OP) begin
      dec_o.undef = 1'b0;
      dec_o.rn    = {1'b0, hw0[5:3]};
      dec_o.rt    = {1'b0, hw0[2:0]};
      dec_o.imm   = {5'b0, hw0[10:6], 2'b00};
      dec_o.index = 1'b1;
      dec_o.add   = 1'b1;
    end else if (hw0[15:11] == NARROW_SP_OP) begin
      dec_o.undef = 1'b0;
      dec_o.rn    = SP_IDX;
      dec_o.rt    = {1'b0, hw0[10:8]};
      dec_o.imm   = {2'b0, hw0[7:0], 2'b00};
      dec_o.index = 1'b1;
      dec_o.add   = 1'b1;
    end
  end
endmodule

// File: rtl/ldr_imm_agen.sv
module ldr_imm_agen
  import ldr_imm_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic [DATA_W-1:0] base_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              add_i,
  input  logic              index_i,
  output logic [DATA_W-1:0] offset_addr_o,
  output logic [DATA_W-1:0] access_addr_o
);
  localparam int unsigned PAD_W = DATA_W - IMM_W;
  logic [DATA_W-1:0] imm_ext;

  assign imm_ext       = {{PAD_W{1'b0}}, imm_i};
  assign offset_addr_o = add_i ? (base_i + imm_ext) : (base_i - imm_ext);
  assign access_addr_o = index_i ? offset_addr_o : base_i;
endmodule

// File: rtl/ldr_imm_seq.sv
module ldr_imm_seq
  import ldr_imm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       skip_i,
  input  logic       gnt_i,
  input  logic       rvalid_i,
  output seq_state_e state_o
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start_i) state_d = skip_i ? ST_DONE : ST_REQ;
      ST_REQ:  if (gnt_i)    state_d = ST_WAIT;
      ST_WAIT: if (rvalid_i) state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ldr_imm_unit.sv
module ldr_imm_unit
  import ldr_imm_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fixed_mode_i,
  input  logic              start_i,
  input  logic [31:0]       instr_i,
  output logic              ready_o,
  output logic [REG_AW-1:0] rf_raddr_o,
  input  logic [DATA_W-1:0] rf_rdata_i,
  output logic              mem_req_o,
  output logic [DATA_W-1:0] mem_addr_o,
  input  logic              mem_gnt_i,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              done_o,
  output logic              rf_we_o,
  output logic [REG_AW-1:0] rf_waddr_o,
  output logic [DATA_W-1:0] rf_wdata_o,
  output logic              wb_we_o,
  output logic [REG_AW-1:0] wb_addr_o,
  output logic [DATA_W-1:0] wb_data_o,
  output logic              branch_o,
  output logic [DATA_W-1:0] branch_target_o,
  output logic              flag_undef_o,
  output logic              flag_literal_o,
  output logic              flag_unpriv_o,
  output logic              flag_unpred_o
);
  ld_dec_t           dec;
  seq_state_e        state;
  logic [DATA_W-1:0] off_addr, acc_addr;
  logic              accept, wb_clash, skip;

  ldr_imm_decode u_dec (
    .instr_i      (instr_i),
    .fixed_mode_i (fixed_mode_i),
    .dec_o        (dec)
  );

  ldr_imm_agen #(.DATA_W(DATA_W)) u_agen (
    .base_i        (rf_rdata_i),
    .imm_i         (dec.imm),
    .add_i         (dec.add),
    .index_i       (dec.index),
    .offset_addr_o (off_addr),
    .access_addr_o (acc_addr)
  );

  assign wb_clash   = dec.wback && (dec.rn == dec.rt) && !dec.undef && !dec.lit && !dec.unpriv;
  assign skip       = dec.undef || dec.lit || dec.unpriv || wb_clash;
  assign accept     = start_i && (state == ST_IDLE);
  assign rf_raddr_o = dec.rn;

  ldr_imm_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .skip_i   (skip),
    .gnt_i    (mem_gnt_i),
    .rvalid_i (mem_rvalid_i),
    .state_o  (state)
  );

  logic [REG_AW-1:0] rn_q, rt_q;
  logic [DATA_W-1:0] off_q, acc_q, data_q;
  logic              wback_q, undef_q, lit_q, unpriv_q, clash_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rn_q     <= '0;
      rt_q     <= '0;
      off_q    <= '0;
      acc_q    <= '0;
      wback_q  <= 1'b0;
      undef_q  <= 1'b0;
      lit_q    <= 1'b0;
      unpriv_q <= 1'b0;
      clash_q  <= 1'b0;
    end else if (accept) begin
      rn_q     <= dec.rn;
      rt_q     <= dec.rt;
      off_q    <= off_addr;
      acc_q    <= acc_addr;
      wback_q  <= dec.wback;
      undef_q  <= dec.undef;
      lit_q    <= dec.lit && !dec.undef;
      unpriv_q <= dec.unpriv && !dec.undef && !dec.lit;
      clash_q  <= wb_clash;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 data_q <= '0;
    else if (state == ST_WAIT && mem_rvalid_i)   data_q <= mem_rdata_i;
  end

  logic done, executed, to_pc, misalign;
  assign done     = (state == ST_DONE);
  assign executed = !(undef_q || lit_q || unpriv_q || clash_q);
  assign to_pc    = (rt_q == PC_IDX);
  assign misalign = to_pc && (acc_q[1:0] != 2'b00);

  assign ready_o         = (state == ST_IDLE);
  assign mem_req_o       = (state == ST_REQ);
  assign mem_addr_o      = acc_q;
  assign done_o          = done;
  assign rf_we_o         = done && executed && !to_pc;
  assign rf_waddr_o      = rt_q;
  assign rf_wdata_o      = data_q;
  assign wb_we_o         = done && executed && wback_q && !misalign;
  assign wb_addr_o       = rn_q;
  assign wb_data_o       = off_q;
  assign branch_o        = done && executed && to_pc && !misalign;
  assign branch_target_o = data_q;
  assign flag_undef_o    = done && undef_q;
  assign flag_literal_o  = done && lit_q;
  assign flag_unpriv_o   = done && unpriv_q;
  assign flag_unpred_o   = done && (clash_q || (executed && misalign));

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_gnt_i |=> mem_req_o && $stable(mem_addr_o));
  p_done_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_req_after_accept_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_req_o) |-> $past(ready_o));
  p_one_flag_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flag_undef_o, flag_literal_o, flag_unpriv_o, flag_unpred_o}));
  p_flag_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_undef_o || flag_literal_o || flag_unpriv_o || flag_unpred_o)
      |-> !(rf_we_o || wb_we_o || branch_o));
  p_wb_with_done_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_we_o |-> done_o);
  p_branch_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    branch_o |-> !rf_we_o);
endmodule

// File: tb/ldr_imm_unit_test.sv
`timescale 1ns/1ps
module ldr_imm_unit_test;
  localparam int DW = 32;
  localparam int K_OK = 0, K_UNDEF = 1, K_LIT = 2, K_UNPRIV = 3, K_UNPRED = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic fixed_mode_i = 1'b0, start_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic ready_o, mem_req_o, mem_gnt_i = 1'b0, mem_rvalid_i = 1'b0, done_o;
  logic [3:0] rf_raddr_o, rf_waddr_o, wb_addr_o;
  logic [DW-1:0] rf_rdata_i, mem_addr_o, mem_rdata_i = '0, rf_wdata_o, wb_data_o, branch_target_o;
  logic rf_we_o, wb_we_o, branch_o;
  logic flag_undef_o, flag_literal_o, flag_unpriv_o, flag_unpred_o;

  int errors = 0, checks = 0;
  int stall = 0, hs_cnt = 0;
  logic hs_pending = 1'b0;
  logic [DW-1:0] hs_addr = '0;

  always #10 clk = ~clk;

  function automatic logic [DW-1:0] rf_val(input logic [3:0] r);
    return 32'h4000_0100 + {16'h0, r, 12'h000};
  endfunction
  function automatic logic [DW-1:0] mem_val(input logic [DW-1:0] a);
    return a ^ 32'h5A5A_F00F;
  endfunction

  assign rf_rdata_i = rf_val(rf_raddr_o);

  ldr_imm_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .fixed_mode_i(fixed_mode_i), .start_i(start_i),
    .instr_i(instr_i), .ready_o(ready_o), .rf_raddr_o(rf_raddr_o), .rf_rdata_i(rf_rdata_i),
    .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_gnt_i(mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i), .mem_rdata_i(mem_rdata_i), .done_o(done_o),
    .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .wb_we_o(wb_we_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
    .branch_o(branch_o), .branch_target_o(branch_target_o),
    .flag_undef_o(flag_undef_o), .flag_literal_o(flag_literal_o),
    .flag_unpriv_o(flag_unpriv_o), .flag_unpred_o(flag_unpred_o)
  );

  // memory responder: grant after stall cycles, data one cycle after grant
  always @(negedge clk) begin
    mem_rvalid_i = hs_pending;
    mem_rdata_i  = hs_pending ? mem_val(hs_addr) : '0;
    hs_pending   = 1'b0;
    mem_gnt_i    = 1'b0;
    if (mem_req_o) begin
      if (stall > 0) stall--;
      else begin
        mem_gnt_i  = 1'b1;
        hs_pending = 1'b1;
        hs_addr    = mem_addr_o;
        hs_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h instr=%h", tag, act, exp, instr_i);
    end
  endtask

  logic c_done, c_rwe, c_wbwe, c_br, c_fu, c_fl, c_fp, c_fd;
  logic [3:0] c_raddr, c_wbaddr;
  logic [DW-1:0] c_rdata, c_wbdata, c_bt;

  task automatic run(input logic [31:0] ins, input logic mode, input int st,
                     input int kind, input logic [3:0] rn, input logic [3:0] rt,
                     input logic idx, input logic add, input logic [11:0] imm,
                     input logic wb, input string tag);
    logic [DW-1:0] base, off, acc, data;
    logic mis;
    @(negedge clk);
    chk(ready_o, "R1 ready", {31'b0, ready_o}, 1);
    fixed_mode_i = mode; instr_i = ins; start_i = 1'b1; stall = st; hs_cnt = 0;
    @(negedge clk);
    start_i = 1'b0;
    c_done = 1'b0;
    for (int c = 0; c < 40; c++) begin
      if (done_o) begin c_done = 1'b1; break; end
      @(negedge clk);
    end
    c_rwe = rf_we_o; c_wbwe = wb_we_o; c_br = branch_o; c_raddr = rf_waddr_o; c_rdata = rf_wdata_o;
    c_wbaddr = wb_addr_o; c_wbdata = wb_data_o; c_bt = branch_target_o;
    c_fu = flag_undef_o; c_fl = flag_literal_o; c_fp = flag_unpriv_o; c_fd = flag_unpred_o;
    chk(c_done, "R12 done", {31'b0, c_done}, 1);
    base = rf_val(rn);
    off  = add ? base + {20'b0, imm} : base - {20'b0, imm};
    acc  = idx ? off : base;
    data = mem_val(acc);
    mis  = (rt == 4'd15) && (acc[1:0] != 2'b00);
    if (kind == K_OK) begin
      chk(hs_cnt == 1, "R12 one read", hs_cnt, 1);
      chk(hs_addr == acc, {tag, " access address"}, hs_addr, acc);
      if (rt == 4'd15) begin
        if (!mis) chk(c_br && c_bt == data && !c_rwe && !c_fd, "R11 branch", c_bt, data);
        else chk(c_fd && !c_br && !c_rwe && !c_wbwe, "R11 misaligned discard",
                 {28'b0, c_fd, c_br, c_rwe, c_wbwe}, 32'h8);
      end else
        chk(c_rwe && c_raddr == rt && c_rdata == data && !c_br, {tag, " target write"}, c_rdata, data);
      if (!mis) begin
        chk(c_wbwe == wb, "R3 write-back enable", {31'b0, c_wbwe}, {31'b0, wb});
        if (wb) chk(c_wbaddr == rn && c_wbdata == off, "R3 write-back value", c_wbdata, off);
        chk(!(c_fu || c_fl || c_fp || c_fd), {tag, " no flag"}, {28'b0, c_fu, c_fl, c_fp, c_fd}, 0);
      end
    end else begin
      chk(hs_cnt == 0, "R10 no access on flagged", hs_cnt, 0);
      chk(!(c_rwe || c_wbwe || c_br), "R10 no writes on flagged", {29'b0, c_rwe, c_wbwe, c_br}, 0);
      chk({c_fu, c_fl, c_fp, c_fd} == 4'(1 << (4 - kind)), {tag, " flag"},
          {28'b0, c_fu, c_fl, c_fp, c_fd}, 32'(1 << (4 - kind)));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R12 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ready_o && !mem_req_o && !done_o && !rf_we_o && !wb_we_o && !branch_o, "R1 reset state",
        {26'b0, ready_o, mem_req_o, done_o, rf_we_o, wb_we_o, branch_o}, 32'h20);

    // R2 fixed-width sweep, with R8/R9/R10 classification
    for (int rn = 0; rn < 16; rn++)
      for (int ti = 0; ti < 3; ti++)
        for (int pw = 0; pw < 4; pw++)
          for (int u = 0; u < 2; u++) begin
            logic [3:0] rt; logic p, w, wb; logic [11:0] imm; int k;
            rt = (ti == 0) ? 4'd0 : (ti == 1) ? 4'(rn) : 4'd15;
            p = pw[1]; w = pw[0]; wb = !p || w;
            imm = 12'((rn * 97 + ti * 13 + pw * 5 + u * 3) & 12'hFFF);
            k = (rn == 15) ? K_LIT : (!p && w) ? K_UNPRIV : (wb && rt == 4'(rn)) ? K_UNPRED : K_OK;
            run({4'hE, 3'b010, p, 1'(u), 1'b0, w, 1'b1, 4'(rn), rt, imm}, 1'b1, (rn + pw) % 3,
                k, 4'(rn), rt, p, 1'(u), imm, wb, "R2");
          end

    // R4 narrow register-base form; upper half is junk
    for (int rn = 0; rn < 8; rn++)
      for (int i5 = 0; i5 < 32; i5++) begin
        logic [3:0] rt; rt = 4'((rn + i5) % 8);
        run({16'hDEAD, 5'b01101, 5'(i5), 3'(rn), rt[2:0]}, 1'b0, i5 % 2,
            K_OK, 4'(rn), rt, 1'b1, 1'b1, 12'(i5 * 4), 1'b0, "R4");
      end

    // R5 register-13 base form
    for (int i8 = 0; i8 < 256; i8 += 3) begin
      logic [3:0] rt; rt = 4'(i8 % 8);
      run({16'hBEEF, 5'b10011, rt[2:0], 8'(i8)}, 1'b0, 0,
          K_OK, 4'd13, rt, 1'b1, 1'b1, 12'(i8 * 4), 1'b0, "R5");
    end

    // R6 wide offset form, R8 literal on base 15
    for (int rn = 0; rn < 16; rn++)
      for (int rt = 0; rt < 16; rt += 3) begin
        logic [11:0] imm; imm = 12'((rn * 311 + rt * 7) & 12'hFFF);
        run({4'(rt), imm, 12'hF8D, 4'(rn)}, 1'b0, rt % 3,
            (rn == 15) ? K_LIT : K_OK, 4'(rn), 4'(rt), 1'b1, 1'b1, imm, 1'b0, "R6");
      end

    // R7 wide indexed form, R9 unprivileged, R10 clash
    for (int rn = 0; rn < 16; rn++)
      for (int ti = 0; ti < 3; ti++)
        for (int puw = 0; puw < 8; puw++) begin
          logic [3:0] rt; logic p, u, w; logic [7:0] imm; int k;
          rt = (ti == 0) ? 4'd2 : (ti == 1) ? 4'(rn) : 4'd15;
          p = puw[2]; u = puw[1]; w = puw[0];
          imm = 8'((rn * 29 + puw * 11 + ti) & 8'hFF);
          k = (rn == 15) ? K_LIT : (p && u && !w) ? K_UNPRIV : (!p && !w) ? K_UNDEF :
              (w && rt == 4'(rn)) ? K_UNPRED : K_OK;
          run({rt, 1'b1, p, u, w, imm, 12'hF85, 4'(rn)}, 1'b0, puw % 2,
              k, 4'(rn), rt, p, u, {4'b0, imm}, w, "R7");
        end

    // R13 / R2 unrecognised encodings
    run({16'h1234, 16'h0000}, 1'b0, 0, K_UNDEF, 0, 0, 1, 1, 0, 0, "R13 narrow");
    run({16'h1234, 16'hF000}, 1'b0, 0, K_UNDEF, 0, 0, 1, 1, 0, 0, "R13 wide");
    run({4'd1, 1'b0, 3'b110, 8'h10, 12'hF85, 4'd2}, 1'b0, 0, K_UNDEF, 0, 0, 1, 1, 0, 0, "R13 bit27");
    run({4'hE, 3'b010, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1, 4'd2, 12'h004}, 1'b1, 0,
        K_UNDEF, 0, 0, 1, 1, 0, 0, "R2 bit22");
    run({4'hE, 3'b011, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'd1, 4'd2, 12'h004}, 1'b1, 0,
        K_UNDEF, 0, 0, 1, 1, 0, 0, "R2 bits27to25");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule